// File: doc/BRIEF.md
# CAN Error State Classifier

This block watches the transmit and receive error counters of a CAN controller and turns each one into a two-bit bus-status code. The codes are registered, so they move one clock after the counters do. Whenever either registered code takes a new value, a sticky status-change flag is raised. Software clears that flag by writing a one to the clear strobe. The interrupt request is the flag gated by an enable bit.

The counters come in as 9-bit values, so a transmit count above 255 can be seen and reported as bus-off. Bus-off is shared by both directions. While the transmitter is off the bus, the receiver reports the bus-off code as well. On the clock where the transmitter leaves bus-off, the receiver code returns straight to OK. The codes run freely in every operating mode, because the block has no input that freezes or clears them apart from reset.

Top module: `can_err_state_mon`

## Requirements
- R1: After reset, both status codes are 00, the status-change flag is 0 and the interrupt request is 0.
- R2: The transmitter code is 00 (OK) for a transmit count of 0 to 96, 01 (warning) for 97 to 127, and 10 (error-passive) for 128 to 255.
- R3: The transmitter code is 11 (bus-off) for a transmit count of 256 or more.
- R4: When the transmitter is not in bus-off and did not leave it on the previous clock, the receiver code uses the same thresholds on the receive count: 00 for 0 to 96, 01 for 97 to 127, and 10 for anything above 127, including values above 255.
- R5: On every clock where the transmitter code is 11, the receiver code is also 11, whatever the receive count is.
- R6: On the clock where the transmitter code leaves 11, the receiver code becomes 00 whatever the receive count is. From the next clock on, the receiver code follows R4 again.
- R7: The codes are registered. A counter change that lands before a clock edge shows on the codes just after that edge.
- R8: The status-change flag becomes 1 on the same edge as any change in either code, and it stays 1 until it is cleared.
- R9: If the clear strobe is 1 at an edge, the flag becomes 0 at that edge, unless a code changes at that same edge, in which case the flag stays 1.
- R10: The interrupt request equals the flag ANDed with the enable input, and it follows the enable input within the same cycle.
- R11: If neither code changes, the flag does not become set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_err_cnt | input | 9 | Transmit error counter value |
| rx_err_cnt | input | 9 | Receive error counter value |
| flag_clr | input | 1 | Write-one-to-clear strobe for the status-change flag |
| irq_en | input | 1 | Interrupt enable for the status-change flag |
| tx_state | output | 2 | Registered transmitter bus-status code |
| rx_state | output | 2 | Registered receiver bus-status code |
| chg_flag | output | 1 | Sticky status-change flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives counts on both sides of each threshold: 96 and 97, 127 and 128, and 255 and 256 on the transmit side. A comparator that is off by one would report the wrong code at exactly these counts. It forces bus-off while the receive count sits in the error-passive range, and then leaves bus-off. A design that copies the receive classification straight through would show 10 instead of 11 during bus-off, and 10 instead of 00 on the exit clock. It also asserts the clear strobe on the same edge as a code change. A design where clear wins would lose that change and report a flag of 0. Runs of steady counts check that a design which sets the flag on every counter write, rather than on every code change, gets caught.

// File: rtl/can_err_pkg.sv
package can_err_pkg;

    typedef enum logic [1:0] {
        BUS_OK      = 2'b00,
        BUS_WARN    = 2'b01,
        BUS_PASSIVE = 2'b10,
        BUS_OFF     = 2'b11
    } bus_state_e;

    typedef struct packed {
        bus_state_e tx;
        bus_state_e rx;
    } dir_state_s;

endpackage

// File: rtl/err_level_classifier.sv
module err_level_classifier
    import can_err_pkg::*;
#(
    parameter int CNT_W       = 9,
    parameter int WARN_LIM    = 96,
    parameter int PASSIVE_LIM = 127,
    parameter int OFF_LIM     = 255,
    parameter bit HAS_OFF     = 1'b1
) (
    input  logic [CNT_W-1:0] cnt,
    output bus_state_e       level
);

    localparam logic [CNT_W-1:0] WARN_T    = CNT_W'(WARN_LIM);
    localparam logic [CNT_W-1:0] PASSIVE_T = CNT_W'(PASSIVE_LIM);
    localparam logic [CNT_W-1:0] OFF_T     = CNT_W'(OFF_LIM);

    bus_state_e below_off;

    always_comb begin
        if (cnt > PASSIVE_T)   below_off = BUS_PASSIVE;
        else if (cnt > WARN_T) below_off = BUS_WARN;
        else                   below_off = BUS_OK;
    end

    generate
        if (HAS_OFF) begin : g_with_off
            always_comb begin
                level = (cnt > OFF_T) ? BUS_OFF : below_off;
            end
        end else begin : g_no_off
            always_comb begin
                level = below_off;
            end
        end
    endgenerate

endmodule

// File: rtl/status_change_flag.sv
module status_change_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic change,
    input  logic clr,
    output logic flag
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = change | (flag_q & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

    // R8: a change at an edge leaves the flag set just after that edge
    assert_set_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        change |=> flag);

    // R8: without a clear, the flag does not drop
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R9: a clear with no change at the same edge drops the flag
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && clr && !change) |=> !flag);

    // R11: with no change, a clear flag stays clear
    assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !change) |=> !flag);

endmodule

// File: rtl/can_err_state_mon.sv
module can_err_state_mon
    import can_err_pkg::*;
#(
    parameter int CNT_W       = 9,
    parameter int WARN_LIM    = 96,
    parameter int PASSIVE_LIM = 127,
    parameter int OFF_LIM     = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_err_cnt,
    input  logic [CNT_W-1:0] rx_err_cnt,
    input  logic             flag_clr,
    input  logic             irq_en,
    output logic [1:0]       tx_state,
    output logic [1:0]       rx_state,
    output logic             chg_flag,
    output logic             irq
);

    localparam logic [CNT_W-1:0] OFF_T  = CNT_W'(OFF_LIM);
    localparam logic [CNT_W-1:0] WARN_T = CNT_W'(WARN_LIM);

    bus_state_e tx_level, rx_level;
    dir_state_s st_d, st_q;
    logic       code_change;

    err_level_classifier #(
        .CNT_W(CNT_W), .WARN_LIM(WARN_LIM), .PASSIVE_LIM(PASSIVE_LIM),
        .OFF_LIM(OFF_LIM), .HAS_OFF(1'b1)
    ) u_tx_cls (
        .cnt   (tx_err_cnt),
        .level (tx_level)
    );

    err_level_classifier #(
        .CNT_W(CNT_W), .WARN_LIM(WARN_LIM), .PASSIVE_LIM(PASSIVE_LIM),
        .OFF_LIM(OFF_LIM), .HAS_OFF(1'b0)
    ) u_rx_cls (
        .cnt   (rx_err_cnt),
        .level (rx_level)
    );

    always_comb begin
        st_d.tx = tx_level;
        if (tx_level == BUS_OFF)
            st_d.rx = BUS_OFF;          // bus-off is shared by both directions
        else if (st_q.tx == BUS_OFF)
            st_d.rx = BUS_OK;           // leaving bus-off resets the receiver
        else
            st_d.rx = rx_level;
        code_change = (st_d != st_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{tx: BUS_OK, rx: BUS_OK};
        else        st_q <= st_d;
    end

    status_change_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .change (code_change),
        .clr    (flag_clr),
        .flag   (chg_flag)
    );

    assign tx_state = st_q.tx;
    assign rx_state = st_q.rx;
    assign irq      = chg_flag & irq_en;

    // R3: a count above the bus-off limit gives bus-off after the edge
    assert_tx_busoff_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err_cnt > OFF_T) |=> (tx_state == 2'b11));

    // R2: a count at or below the warning limit gives OK after the edge
    assert_tx_ok_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err_cnt <= WARN_T) |=> (tx_state == 2'b00));

    // R5: the receiver reports bus-off whenever the transmitter does
    assert_shared_busoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_state == 2'b11) |-> (rx_state == 2'b11));

    // R6: leaving bus-off sends the receiver straight to OK
    assert_busoff_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_state == 2'b11) && (tx_err_cnt <= OFF_T)) |=> (rx_state == 2'b00));

    // R8: a new code value comes with a set flag
    assert_change_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(tx_state) || !$stable(rx_state)) |-> chg_flag);

endmodule

// File: tb/tb_can_err_state_mon.sv
`timescale 1ns/1ps
module tb_can_err_state_mon;

    typedef struct {
        logic [1:0] tx;
        logic [1:0] rx;
        logic       flag;
        logic       irq;
        string      tag;
    } exp_s;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] tx_err_cnt = '0;
    logic [8:0] rx_err_cnt = '0;
    logic       flag_clr = 1'b0;
    logic       irq_en = 1'b0;
    logic [1:0] tx_state, rx_state;
    logic       chg_flag, irq;

    int n_checks = 0;
    int n_fail = 0;
    exp_s exp_q[$];
    logic [1:0] m_tx = 2'b00, m_rx = 2'b00;
    logic       m_flag = 1'b0;

    always #2 clk = ~clk;

    can_err_state_mon dut (
        .clk(clk), .rst_n(rst_n), .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
        .flag_clr(flag_clr), .irq_en(irq_en), .tx_state(tx_state), .rx_state(rx_state),
        .chg_flag(chg_flag), .irq(irq)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [1:0] level(input logic [8:0] c, input bit off_ok);
        if (off_ok && c >= 9'd256) return 2'b11;
        if (c >= 9'd128)           return 2'b10;
        if (c >= 9'd97)            return 2'b01;
        return 2'b00;
    endfunction

    task automatic step(input int tx, input int rx, input bit clr, input bit en, input string tag);
        logic [1:0] ntx, nrx;
        exp_s e;
        @(negedge clk);
        tx_err_cnt = 9'(tx);
        rx_err_cnt = 9'(rx);
        flag_clr   = clr;
        irq_en     = en;
        @(posedge clk);
        ntx = level(tx_err_cnt, 1'b1);
        if (ntx == 2'b11)      nrx = 2'b11;
        else if (m_tx == 2'b11) nrx = 2'b00;
        else                   nrx = level(rx_err_cnt, 1'b0);
        m_flag = (ntx != m_tx) || (nrx != m_rx) || (m_flag && !clr);
        m_tx = ntx;
        m_rx = nrx;
        e.tx = m_tx; e.rx = m_rx; e.flag = m_flag; e.irq = m_flag & en; e.tag = tag;
        exp_q.push_back(e);
    endtask

    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_s e;
            e = exp_q.pop_front();
            check(e.tag, "tx_state", tx_state, e.tx);
            check(e.tag, "rx_state", rx_state, e.rx);
            check(e.tag, "chg_flag", chg_flag, e.flag);
            check(e.tag, "irq", irq, e.irq);
        end
    end

    initial begin
        #20000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", "tx_state", tx_state, 0);
        check("R1", "rx_state", rx_state, 0);
        check("R1", "chg_flag", chg_flag, 0);
        check("R1", "irq", irq, 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(0,   0,   0, 1, "R11 idle after reset");
        step(96,  0,   0, 1, "R2 tx 96 ok");
        step(97,  0,   0, 1, "R2 tx 97 warn / R7 / R8");
        step(97,  0,   0, 1, "R8 flag held");
        step(97,  0,   1, 1, "R9 clear");
        step(127, 0,   0, 1, "R11 tx 127 still warn");
        step(128, 0,   0, 0, "R2 tx 128 passive / R10 en low");
        step(128, 0,   0, 1, "R10 en high");
        step(255, 0,   1, 1, "R2 tx 255 passive / R9");
        step(256, 200, 0, 1, "R3 tx 256 busoff / R5");
        step(256, 200, 1, 1, "R9 clear in busoff");
        step(511, 50,  0, 1, "R5 rx ignored in busoff / R11");
        step(100, 200, 0, 1, "R6 exit busoff rx ok");
        step(100, 200, 1, 1, "R6 rx follows count / R9 change beats clear");
        step(100, 96,  1, 1, "R4 rx 96 ok");
        step(100, 96,  1, 1, "R9 cleared");
        step(100, 97,  0, 1, "R4 rx 97 warn");
        step(100, 127, 1, 1, "R4 rx 127 warn / R9");
        step(100, 128, 1, 1, "R4 rx 128 passive");
        step(100, 300, 1, 1, "R4 rx 300 passive no busoff");
        step(0,   0,   0, 1, "R2 back to ok");
        @(negedge clk);
        flag_clr = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule